// File: doc/BRIEF.md
# I2C Bus Master with Mailbox Commands

This block is a single-master I2C controller that a host runs through six 16-bit registers. The host puts up to two payload bytes in a write-data register and then writes one command word into the command mailbox. That word names a 7-bit target, a direction, a byte count of one or two, and whether the bus stays owned afterwards. The master then runs the whole transfer on its own: START, address byte with R/W bit, data bytes with acknowledge slots, and STOP. It latches a completion or error event in a status register that the host clears by writing ones.

When a command asks to keep the bus, the STOP is left out and the clock line is held low. The next command then opens with a repeated START. This lets a host chain several short commands into one longer or combined transaction, for example a register-pointer write followed by a read. A single-byte read to an address works as a presence probe: an unacknowledged address is reported as an error.

Register offsets (word index on `reg_addr`) are: 0 status, 1 interrupt enable, 2 write data, 3 command mailbox, 4 read data, 5 last accepted command. The sequencer states are IDLE (bus free), RSTART (clock raised again after a hold), START, ADDR (address byte and ack), WDATA (byte out and ack), RDATA (byte in and master ack or nack), STOP (two bit slots), and HOLD (bus owned, clock low). The transitions are:
- IDLE→START and HOLD→RSTART when a command is accepted.
- RSTART→START.
- START→ADDR.
- ADDR→WDATA, ADDR→RDATA, or ADDR→STOP on a NACK.
- WDATA→WDATA for the second byte.
- WDATA→HOLD or WDATA→STOP, and RDATA→RDATA, RDATA→HOLD or RDATA→STOP.
- STOP→IDLE.

Top module: `i2c_mb_master`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and neither bus line is driven low.
- R2: A write to offset 3 starts a transfer only if bits 15:14 equal binary 10 and the sequencer is in IDLE or HOLD. Any other such write is ignored: no bus activity occurs, and offset 5 keeps the last accepted command word.
- R3: In a write command (bit 10 = 1), write-data bits 7:0 go on the bus first. Bits 15:8 follow only if bit 11 is set. Success sets status bit 14.
- R4: The address byte sent is command bits 7:1 followed by an R/W bit. The R/W bit is 0 for a write and 1 for a read.
- R5: In a read command (bit 10 = 0), the first byte received lands in read-data bits 7:0. The second byte lands in bits 15:8 when bit 11 is set; a one-byte read clears bits 15:8. Success sets status bit 15.
- R6: If the target NACKs the address, status bit 13 is set in place of bit 14 or 15, and a STOP is issued.
- R7: With command bit 13 set, a successful transfer ends without a STOP and SCL is held low. The next accepted command begins with a repeated START.
- R8: During reads the master ACKs every byte except the last byte of the command, which it NACKs.
- R9: A NACK on a written data byte aborts the command. The abort sets status bit 13 and issues a STOP even when bit 13 of the command asked to hold the bus.
- R10: Status bits 13, 14 and 15 stay set until the host writes 1 to that bit at offset 0. Writing 0 to a bit leaves it unchanged.
- R11: `irq` is high exactly while some status bit and the same bit of the enable register (offset 1) are both 1.
- R12: Offset 5 reads back the full command word most recently accepted.
- R13: One SCL period is 8 steps of CLK_HZ/(SCL_HZ*8) clock cycles, with SCL low for the first 4 steps. SDA changes only while SCL is low, except at START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A corrupted sequencer state or bit counter shows up at the pins within one bit slot. It appears as SDA moving while SCL is high outside START and STOP, or as a byte with the wrong bit count, which the bench's target model then decodes as a wrong address or wrong data. A wrong byte index or hold flag shows up within one command as a missing or extra STOP, a wrong repeated-START count, or an ACK where a NACK belongs. A wrong event latch shows up as soon as the host reads the status register after the command completes.

// File: rtl/i2c_mb_pkg.sv
package i2c_mb_pkg;
    localparam logic [2:0] OFS_STAT = 3'd0;
    localparam logic [2:0] OFS_IEN  = 3'd1;
    localparam logic [2:0] OFS_WDAT = 3'd2;
    localparam logic [2:0] OFS_CMD  = 3'd3;
    localparam logic [2:0] OFS_RDAT = 3'd4;
    localparam logic [2:0] OFS_RCMD = 3'd5;

    localparam int B_TX   = 14;
    localparam int C_WR   = 10;
    localparam int C_TWO  = 11;
    localparam int C_HOLD = 13;
    localparam logic [1:0] C_FMT = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE, S_RSTART, S_START, S_ADDR, S_WDATA, S_RDATA, S_STOP, S_HOLD
    } eng_state_t;

    typedef enum logic [1:0] { FIN_TX, FIN_RX, FIN_ERR } fin_t;

    typedef struct packed {
        logic [6:0] addr;
        logic       wr;
        logic       two;
        logic       hold;
    } cmd_t;
endpackage

// File: rtl/i2c_mb_tick.sv
module i2c_mb_tick #(
    parameter int STEP = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (STEP > 1) ? $clog2(STEP) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!en || tick)  cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_mb_engine.sv
module i2c_mb_engine
    import i2c_mb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        go,
    input  cmd_t        cmd_in,
    input  logic [15:0] wdata,
    input  logic        sda_in,
    output logic        run,
    output logic        ev_tx,
    output logic        ev_rx,
    output logic        ev_err,
    output logic [15:0] rdata,
    output logic        scl_oe,
    output logic        sda_oe
);
    eng_state_t  state_q;
    logic [2:0]  ph_q;
    logic [3:0]  bit_q;
    logic        byte_q, nack_q;
    logic [7:0]  sh_q;
    logic [15:0] wd_q;
    cmd_t        cmd_q;
    fin_t        fin_q;
    logic        scl_d, sda_d;

    wire slot_end = tick && (ph_q == 3'd7);
    wire sample   = tick && (ph_q == 3'd6);
    wire ack_slot = (bit_q == 4'd8);

    assign run = !(state_q inside {S_IDLE, S_HOLD});

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ph_q    <= '0;
            bit_q   <= '0;
            byte_q  <= 1'b0;
            nack_q  <= 1'b0;
            sh_q    <= '0;
            wd_q    <= '0;
            cmd_q   <= '0;
            fin_q   <= FIN_TX;
            rdata   <= '0;
            ev_tx   <= 1'b0;
            ev_rx   <= 1'b0;
            ev_err  <= 1'b0;
        end else begin
            ev_tx  <= 1'b0;
            ev_rx  <= 1'b0;
            ev_err <= 1'b0;
            if (tick) ph_q <= ph_q + 3'd1;
            unique case (state_q)
                S_IDLE, S_HOLD: if (go) begin
                    cmd_q   <= cmd_in;
                    wd_q    <= wdata;
                    ph_q    <= '0;
                    bit_q   <= '0;
                    byte_q  <= 1'b0;
                    state_q <= (state_q == S_IDLE) ? S_START : S_RSTART;
                end
                S_RSTART: if (slot_end) state_q <= S_START;
                S_START: if (slot_end) begin
                    state_q <= S_ADDR;
                    sh_q    <= {cmd_q.addr, ~cmd_q.wr};
                    bit_q   <= '0;
                end
                S_ADDR, S_WDATA: begin
                    if (sample && ack_slot) nack_q <= sda_in;
                    if (slot_end) begin
                        if (!ack_slot) begin
                            sh_q  <= {sh_q[6:0], 1'b0};
                            bit_q <= bit_q + 4'd1;
                        end else begin
                            bit_q <= '0;
                            if (nack_q) begin
                                fin_q   <= FIN_ERR;
                                state_q <= S_STOP;
                            end else if (state_q == S_ADDR) begin
                                byte_q  <= 1'b0;
                                sh_q    <= wd_q[7:0];
                                state_q <= cmd_q.wr ? S_WDATA : S_RDATA;
                            end else if (cmd_q.two && !byte_q) begin
                                byte_q <= 1'b1;
                                sh_q   <= wd_q[15:8];
                            end else if (cmd_q.hold) begin
                                ev_tx   <= 1'b1;
                                state_q <= S_HOLD;
                            end else begin
                                fin_q   <= FIN_TX;
                                state_q <= S_STOP;
                            end
                        end
                    end
                end
                S_RDATA: begin
                    if (sample && !ack_slot) sh_q <= {sh_q[6:0], sda_in};
                    if (slot_end) begin
                        if (!ack_slot) begin
                            bit_q <= bit_q + 4'd1;
                        end else begin
                            bit_q <= '0;
                            if (!byte_q) rdata <= {8'h00, sh_q};
                            else         rdata[15:8] <= sh_q;
                            if (cmd_q.two && !byte_q) begin
                                byte_q <= 1'b1;
                            end else if (cmd_q.hold) begin
                                ev_rx   <= 1'b1;
                                state_q <= S_HOLD;
                            end else begin
                                fin_q   <= FIN_RX;
                                state_q <= S_STOP;
                            end
                        end
                    end
                end
                S_STOP: if (slot_end) begin
                    if (bit_q == 4'd0) begin
                        bit_q <= 4'd1;
                    end else begin
                        state_q <= S_IDLE;
                        ev_tx   <= (fin_q == FIN_TX);
                        ev_rx   <= (fin_q == FIN_RX);
                        ev_err  <= (fin_q == FIN_ERR);
                    end
                end
            endcase
        end
    end

    // Bus drive: 1 means pull low; phase 0 of a bit slot keeps SDA as it was
    always_comb begin
        scl_d = 1'b0;
        sda_d = sda_oe;
        unique case (state_q)
            S_IDLE:   sda_d = 1'b0;
            S_HOLD:   begin scl_d = 1'b1; sda_d = 1'b0; end
            S_RSTART: begin scl_d = !ph_q[2]; sda_d = 1'b0; end
            S_START:  sda_d = ph_q[2];
            S_ADDR, S_WDATA: begin
                scl_d = !ph_q[2];
                if (ph_q != 3'd0) sda_d = ack_slot ? 1'b0 : ~sh_q[7];
            end
            S_RDATA: begin
                scl_d = !ph_q[2];
                if (ph_q != 3'd0) sda_d = ack_slot && cmd_q.two && !byte_q;
            end
            S_STOP: begin
                if (bit_q == 4'd0) begin
                    scl_d = !ph_q[2];
                    if (ph_q != 3'd0) sda_d = 1'b1;
                end else begin
                    sda_d = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            scl_oe <= scl_d;
            sda_oe <= sda_d;
        end
    end

    // R2: the latched command cannot move while a transfer runs
    a_r2_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(cmd_q));

    // R7: an owned bus keeps the clock pulled low
    a_r7_hold_keeps_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && $past(state_q) == S_HOLD) |-> scl_oe);

    // R13: data line moves only under a low clock outside START/STOP
    a_r13_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe) && state_q != S_START && state_q != S_STOP)
            |-> (scl_oe && $past(scl_oe)));

    // R9: an error is only reported once the bus is released
    a_r9_err_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |-> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2c_mb_master.sv
module i2c_mb_master
    import i2c_mb_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int SCL_HZ = 50_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe
);
    localparam int STEP_RAW = CLK_HZ / (SCL_HZ * 8);
    localparam int STEP     = (STEP_RAW < 1) ? 1 : STEP_RAW;

    logic [2:0]  stat_q, ien_q;      // [0]=bit13 err, [1]=bit14 tx, [2]=bit15 rx
    logic [15:0] wdat_q, rcmd_q, rdata;
    logic        tick, run, go, ev_tx, ev_rx, ev_err;
    cmd_t        cmd_in;

    wire wr_stat = reg_we && (reg_addr == OFS_STAT);
    assign go = reg_we && (reg_addr == OFS_CMD) && (reg_wdata[15:14] == C_FMT) && !run;
    assign cmd_in = '{addr: reg_wdata[7:1], wr: reg_wdata[C_WR],
                      two: reg_wdata[C_TWO], hold: reg_wdata[C_HOLD]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            ien_q  <= '0;
            wdat_q <= '0;
            rcmd_q <= '0;
        end else begin
            stat_q <= (stat_q & ~(wr_stat ? reg_wdata[15:13] : 3'b000))
                    | {ev_rx, ev_tx, ev_err};
            if (reg_we && reg_addr == OFS_IEN)  ien_q  <= reg_wdata[15:13];
            if (reg_we && reg_addr == OFS_WDAT) wdat_q <= reg_wdata;
            if (go)                             rcmd_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_STAT: reg_rdata = {stat_q, 13'd0};
            OFS_IEN:  reg_rdata = {ien_q, 13'd0};
            OFS_WDAT: reg_rdata = wdat_q;
            OFS_RDAT: reg_rdata = rdata;
            OFS_RCMD: reg_rdata = rcmd_q;
            default:  reg_rdata = 16'd0;
        endcase
    end

    assign irq = |(stat_q & ien_q);

    i2c_mb_tick #(.STEP(STEP)) tick_i (
        .clk(clk), .rst_n(rst_n), .en(run), .tick(tick)
    );

    i2c_mb_engine eng_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .cmd_in(cmd_in),
        .wdata(wdat_q), .sda_in(sda_in), .run(run), .ev_tx(ev_tx),
        .ev_rx(ev_rx), .ev_err(ev_err), .rdata(rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // R10: a set completion bit survives until the host writes 1 to it
    a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !(wr_stat && reg_wdata[B_TX])) |=> stat_q[1]);
endmodule

// File: tb/i2c_mb_master_tb_top.sv
`timescale 1ns/1ps
module i2c_mb_master_tb_top;
    localparam logic [6:0] SLV = 7'h50;
    localparam int PER = 32;   // 8 steps of 4 cycles

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic [2:0]  reg_addr;
    logic        reg_we;
    logic [15:0] reg_wdata, reg_rdata;
    logic        irq, scl_oe, sda_oe, slv_drv;
    logic        scl_line, sda_line;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slv_drv);

    i2c_mb_master #(.CLK_HZ(200_000_000), .SCL_HZ(6_250_000)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0, last_rise = 0, scl_per = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---- target model ----
    int sl_bit = 0, sl_ph = 0;        // ph: 0 ignore, 1 addr, 2 write, 3 read
    logic [7:0] sl_sh = 0, sl_rb = 0, last_ab = 0;
    bit sl_match, sl_rw, sl_mack, sl_busy = 0, nack_data = 0;
    logic [7:0] rbytes [8];
    logic [7:0] wlog [64];
    int rn = 0, wn = 0, n_start = 0, n_rstart = 0, n_stop = 0, n_mack = 0, n_mnack = 0;

    initial slv_drv = 1'b0;

    always @(posedge scl_line) begin
        scl_per = cyc - last_rise;
        last_rise = cyc;
    end

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        if (sl_busy) n_rstart++; else n_start++;
        sl_busy = 1; sl_ph = 1; sl_bit = 0; sl_sh = 0;
    end

    always @(posedge sda_line) if (scl_line === 1'b1 && sl_busy) begin
        n_stop++; sl_busy = 0; sl_ph = 0; slv_drv = 0;
    end

    always @(posedge scl_line) if (sl_ph != 0) begin
        if (sl_bit < 8) begin
            if (sl_ph != 3) sl_sh = {sl_sh[6:0], sda_line};
            sl_bit++;
        end else if (sl_bit == 8) begin
            if (sl_ph == 3) begin
                sl_mack = (sda_line == 1'b0);
                if (sl_mack) n_mack++; else n_mnack++;
            end
            sl_bit = 9;
        end
    end

    always @(negedge scl_line) if (sl_ph != 0 && scl_line === 1'b0) begin
        if (sl_bit == 8) begin
            if (sl_ph == 1) begin
                last_ab = sl_sh; sl_match = (sl_sh[7:1] == SLV); sl_rw = sl_sh[0];
                slv_drv = sl_match;
            end else if (sl_ph == 2) begin
                wlog[wn % 64] = sl_sh; wn++;
                slv_drv = !nack_data; sl_mack = !nack_data;
            end else slv_drv = 0;
        end else if (sl_bit == 9) begin
            sl_bit = 0; slv_drv = 0;
            if (sl_ph == 1) begin
                if (!sl_match) sl_ph = 0;
                else if (sl_rw) begin
                    sl_ph = 3; sl_rb = rbytes[rn % 8]; rn++; slv_drv = ~sl_rb[7];
                end else sl_ph = 2;
            end else if (sl_ph == 2) begin
                if (!sl_mack) sl_ph = 0;
            end else if (sl_mack) begin
                sl_rb = rbytes[rn % 8]; rn++; slv_drv = ~sl_rb[7];
            end else sl_ph = 0;
        end else if (sl_ph == 3) begin
            slv_drv = ~sl_rb[7 - sl_bit];
        end
    end

    // ---- helpers ----
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    function automatic logic [15:0] mk(input logic [6:0] a, input bit wr, input bit two, input bit hold);
        return {2'b10, hold, 1'b0, two, wr, 2'b00, a, 1'b0};
    endfunction

    task automatic wait_evt(output logic [15:0] st);
        st = 0;
        for (int i = 0; i < 20000 && st[15:13] == 3'b000; i++) rd_reg(3'd0, st);
    endtask

    task automatic xfer(input logic [15:0] cmd, input logic [15:0] wd, output logic [15:0] st);
        wr_reg(3'd2, wd);
        wr_reg(3'd3, cmd);
        wait_evt(st);
    endtask

    function automatic logic [15:0] exp_rd(input logic [7:0] b0, input logic [7:0] b1, input bit two);
        return two ? {b1, b0} : {8'h00, b0};
    endfunction

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] st, v;
        int w0, s0, r0, a0, k0;
        void'($urandom(32'd4242));
        rst_n = 1'b0; reg_addr = 0; reg_we = 0; reg_wdata = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd_reg(3'(a), v); chk("R1 reg", v, 0);
        end
        chk("R1 irq", irq, 0); chk("R1 scl", scl_line, 1); chk("R1 sda", sda_line, 1);

        // R3 R4 two-byte write
        w0 = wn; s0 = n_stop;
        xfer(mk(SLV, 1, 1, 0), 16'hB7A4, st);
        chk("R3 status", st, 16'h4000);
        chk("R3 count", wn - w0, 2);
        chk("R3 low first", wlog[w0 % 64], 8'hA4);
        chk("R3 high second", wlog[(w0 + 1) % 64], 8'hB7);
        chk("R4 addr byte wr", last_ab, {SLV, 1'b0});
        chk("R13 scl period", scl_per, PER);
        chk("R6 stop count", n_stop - s0, 1);
        wr_reg(3'd0, 16'hE000);

        // R3 one-byte write
        w0 = wn;
        xfer(mk(SLV, 1, 0, 0), 16'h3C5D, st);
        chk("R3 status 1b", st, 16'h4000);
        chk("R3 count 1b", wn - w0, 1);
        chk("R3 data 1b", wlog[w0 % 64], 8'h5D);
        wr_reg(3'd0, 16'hE000);

        // R5 R8 two-byte read
        rn = 0; rbytes[0] = 8'h9E; rbytes[1] = 8'h21;
        a0 = n_mack; k0 = n_mnack;
        xfer(mk(SLV, 0, 1, 0), 16'h0, st);
        chk("R5 status", st, 16'h8000);
        rd_reg(3'd4, v); chk("R5 rdata 2b", v, 16'h219E);
        chk("R4 addr byte rd", last_ab, {SLV, 1'b1});
        chk("R8 acks", n_mack - a0, 1);
        chk("R8 nacks", n_mnack - k0, 1);
        wr_reg(3'd0, 16'hE000);

        // R5 R8 one-byte read clears high byte
        rn = 0; rbytes[0] = 8'h44;
        a0 = n_mack; k0 = n_mnack;
        xfer(mk(SLV, 0, 0, 0), 16'h0, st);
        rd_reg(3'd4, v); chk("R5 rdata 1b", v, 16'h0044);
        chk("R8 no ack 1b", n_mack - a0, 0);
        chk("R8 nack 1b", n_mnack - k0, 1);
        wr_reg(3'd0, 16'hE000);

        // R6 probe of an absent address
        s0 = n_stop;
        xfer(mk(7'h11, 0, 0, 0), 16'h0, st);
        chk("R6 probe err", st, 16'h2000);
        chk("R6 probe stop", n_stop - s0, 1);
        wr_reg(3'd0, 16'hE000);

        // R7 hold then repeated START read
        s0 = n_stop; r0 = n_rstart; w0 = wn;
        xfer(mk(SLV, 1, 0, 1), 16'h0012, st);
        chk("R7 hold status", st, 16'h4000);
        repeat (10) @(negedge clk);
        chk("R7 scl held low", scl_line, 0);
        chk("R7 no stop", n_stop - s0, 0);
        wr_reg(3'd0, 16'hE000);
        rn = 0; rbytes[0] = 8'h6B; rbytes[1] = 8'hF0;
        xfer(mk(SLV, 0, 1, 0), 16'h0, st);
        chk("R7 rstart", n_rstart - r0, 1);
        chk("R7 one stop", n_stop - s0, 1);
        chk("R7 pointer", wlog[w0 % 64], 8'h12);
        rd_reg(3'd4, v); chk("R7 rdata", v, 16'hF06B);
        wr_reg(3'd0, 16'hE000);

        // R9 data NACK with hold requested
        nack_data = 1; s0 = n_stop; w0 = wn;
        xfer(mk(SLV, 1, 1, 1), 16'h7788, st);
        nack_data = 0;
        chk("R9 err", st, 16'h2000);
        chk("R9 aborted", wn - w0, 1);
        chk("R9 stop", n_stop - s0, 1);
        chk("R9 scl free", scl_line, 1);
        chk("R9 sda free", sda_line, 1);
        wr_reg(3'd0, 16'hE000);

        // R10 R11 clear and interrupt
        wr_reg(3'd1, 16'h4000);
        xfer(mk(SLV, 1, 0, 0), 16'h0001, st);
        #1 chk("R11 irq on", irq, 1);
        wr_reg(3'd0, 16'h2000);
        rd_reg(3'd0, v); chk("R10 zero write keeps", v, 16'h4000);
        chk("R11 irq kept", irq, 1);
        wr_reg(3'd1, 16'h8000);
        #1 chk("R11 irq masked", irq, 0);
        wr_reg(3'd1, 16'h4000);
        wr_reg(3'd0, 16'h4000);
        rd_reg(3'd0, v); chk("R10 cleared", v, 16'h0000);
        chk("R11 irq off", irq, 0);
        wr_reg(3'd1, 16'h0000);

        // R2 R12 command while busy is ignored
        w0 = wn;
        wr_reg(3'd2, 16'h00C3);
        wr_reg(3'd3, mk(SLV, 1, 0, 0));
        wr_reg(3'd3, mk(7'h22, 0, 1, 0));
        wait_evt(st);
        chk("R2 busy only tx", st, 16'h4000);
        chk("R2 busy one byte", wn - w0, 1);
        rd_reg(3'd5, v); chk("R12 last cmd", v, mk(SLV, 1, 0, 0));
        wr_reg(3'd0, 16'hE000);

        // R2 wrong format ignored
        s0 = n_start;
        wr_reg(3'd3, {2'b01, 14'h00A0});
        repeat (600) @(negedge clk);
        rd_reg(3'd0, v); chk("R2 fmt no event", v, 0);
        chk("R2 fmt no start", n_start - s0, 0);
        rd_reg(3'd5, v); chk("R12 fmt keeps", v, mk(SLV, 1, 0, 0));

        // random mix
        for (int it = 0; it < 12; it++) begin
            bit wr, two;
            logic [15:0] d, e;
            wr = bit'($urandom_range(0, 1));
            two = bit'($urandom_range(0, 1));
            d = 16'($urandom);
            w0 = wn; rn = 0; rbytes[0] = d[7:0] ^ 8'h5A; rbytes[1] = d[15:8] ^ 8'hA5;
            xfer(mk(SLV, wr, two, 0), d, st);
            if (wr) begin
                chk("R3 rnd status", st, 16'h4000);
                chk("R3 rnd lo", wlog[w0 % 64], d[7:0]);
                if (two) chk("R3 rnd hi", wlog[(w0 + 1) % 64], d[15:8]);
                chk("R3 rnd count", wn - w0, two ? 2 : 1);
            end else begin
                chk("R5 rnd status", st, 16'h8000);
                e = exp_rd(d[7:0] ^ 8'h5A, d[15:8] ^ 8'hA5, two);
                rd_reg(3'd4, v); chk("R5 rnd rdata", v, e);
            end
            chk("R13 rnd period", scl_per, PER);
            wr_reg(3'd0, 16'hE000);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule